// File: doc/BRIEF.md
# Short-Transaction SPI Command Engine

This block is a small SPI master driven through an eight-byte register window. Software loads a command byte, up to three address bytes and one extra data byte. A single write to the control register then sets how many bytes go out and how many come back, and starts the transfer. The engine drives chip select, shifts the outgoing bytes in SPI mode 0 and captures up to three response bytes. While it works, a busy flag is set.

The outgoing length is chosen from a fixed set of 1, 2, 4 or 5 bytes through a two-bit code. Address bytes go onto the wire starting from the highest register offset. Received bytes land in the upper part of the window. The serial clock runs at one of two rates. Each rate is a parameter that gives the length of an SCLK half period in system clocks.

Top module: `spi_short_xfer`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, and every offset of the window reads 0, including the busy flag (bit 7 of offset 0).
- R2: A write to offset 0 while idle stores bits [6:0], which read back in bits [6:0] of offset 0. It starts a transfer only when bits [6:4] equal 4 (slow) or 5 (fast). Once started, bit 7 of offset 0 reads 1 from the following cycle. Any other value in [6:4] starts nothing.
- R3: Control bits [1:0] select the outgoing length: 0, 1, 2 and 3 send 1, 2, 4 and 5 bytes. Control bits [3:2] select 0 to 3 incoming bytes. The transfer carries exactly 8 times the sum of those two counts in SCLK cycles.
- R4: The command byte (offset 1) always goes out first. In 4- and 5-byte transfers it is followed by offset 4, then offset 3, then offset 2. The byte at offset 7 goes out last in 2- and 5-byte transfers.
- R5: Incoming bytes, most significant bit first, are stored in order of reception at offsets 5, 6 and 7. Offsets beyond the read count keep their earlier contents. A read of offset 7 returns the third received byte, and a write to offset 7 loads the outgoing extra byte.
- R6: SPI mode 0: sclk is low whenever cs_n is high. mosi changes only while sclk is low and carries the most significant bit first. It is 0 during the incoming phase, and miso is sampled on the rising edge.
- R7: The SCLK period is 2*HALF_SLOW system clocks when the start field is 4, and 2*HALF_FAST when it is 5.
- R8: cs_n goes low in the cycle after the starting write and stays low until half an SCLK period after the last falling edge. The busy flag clears exactly one cycle after cs_n rises.
- R9: While busy, every register write is ignored. This includes a second control write, which neither starts nor changes a transfer.
- R10: Writes to offsets 5 and 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register offset for both read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sclk | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The bench builds the block with HALF_FAST=2 and HALF_SLOW=5. This makes the two SCLK periods 4 and 10 system clocks, so a period measurement at the pin tells the speeds apart. Transfers also last long enough that writes can land in the middle of one. A table covers every length code with several read counts and both speeds. Directed cases then probe control writes while busy, invalid start fields, the read-only receive offsets and retention of bytes that were not received.

// File: rtl/spi_sx_pkg.sv
package spi_sx_pkg;

  localparam int BYTE_W     = 8;
  localparam int TX_MAX     = 5;
  localparam int RX_MAX     = 3;
  localparam int TX_VEC_W   = TX_MAX * BYTE_W;
  localparam int BIT_CNT_W  = $clog2((TX_MAX + RX_MAX) * BYTE_W + 1);

  localparam logic [2:0] SPD_SLOW = 3'd4;
  localparam logic [2:0] SPD_FAST = 3'd5;

  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_CMD   = 3'd1;
  localparam logic [2:0] OFS_ADR_L = 3'd2;
  localparam logic [2:0] OFS_ADR_M = 3'd3;
  localparam logic [2:0] OFS_ADR_H = 3'd4;
  localparam logic [2:0] OFS_RX0   = 3'd5;
  localparam logic [2:0] OFS_RX1   = 3'd6;
  localparam logic [2:0] OFS_XTRA  = 3'd7;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SHIFT, SQ_TAIL, SQ_DONE} sq_state_t;

  typedef struct packed {
    logic [BYTE_W-1:0] cmd;
    logic [BYTE_W-1:0] adr_h;
    logic [BYTE_W-1:0] adr_m;
    logic [BYTE_W-1:0] adr_l;
    logic [BYTE_W-1:0] xtra;
  } tx_bytes_t;

  // Outgoing byte count for a two-bit length code.
  function automatic logic [2:0] tx_len(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  // Outgoing bytes, left aligned, first byte on the wire in the top bits.
  function automatic logic [TX_VEC_W-1:0] pack_tx(input logic [1:0] code,
                                                  input tx_bytes_t b);
    case (code)
      2'd0:    return {b.cmd, 32'h0};
      2'd1:    return {b.cmd, b.xtra, 24'h0};
      2'd2:    return {b.cmd, b.adr_h, b.adr_m, b.adr_l, 8'h0};
      default: return {b.cmd, b.adr_h, b.adr_m, b.adr_l, b.xtra};
    endcase
  endfunction

  function automatic logic [BIT_CNT_W-1:0] tx_bits(input logic [1:0] code);
    return BIT_CNT_W'(tx_len(code)) << 3;
  endfunction

  function automatic logic [BIT_CNT_W-1:0] all_bits(input logic [1:0] code,
                                                    input logic [1:0] rcnt);
    return tx_bits(code) + (BIT_CNT_W'(rcnt) << 3);
  endfunction

endpackage

// File: rtl/spi_sx_regs.sv
module spi_sx_regs
  import spi_sx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              busy,
  input  logic              rx_we,
  input  logic [1:0]        rx_idx,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              start,
  output logic [1:0]        start_code,
  output logic [1:0]        start_rcnt,
  output logic              start_fast,
  output tx_bytes_t         txb
);

  logic [6:0]        ctrl_q;
  tx_bytes_t         txb_q;
  logic [BYTE_W-1:0] rx_q [RX_MAX];
  logic              wr_ok;
  logic [2:0]        spd_field;

  assign wr_ok      = wr && !busy;
  assign spd_field  = wdata[6:4];
  assign start      = wr_ok && (addr == OFS_CTRL) &&
                      ((spd_field == SPD_SLOW) || (spd_field == SPD_FAST));
  assign start_code = wdata[1:0];
  assign start_rcnt = wdata[3:2];
  assign start_fast = (spd_field == SPD_FAST);
  assign txb        = txb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      txb_q  <= '0;
    end else if (wr_ok) begin
      case (addr)
        OFS_CTRL:  ctrl_q      <= wdata[6:0];
        OFS_CMD:   txb_q.cmd   <= wdata;
        OFS_ADR_L: txb_q.adr_l <= wdata;
        OFS_ADR_M: txb_q.adr_m <= wdata;
        OFS_ADR_H: txb_q.adr_h <= wdata;
        OFS_XTRA:  txb_q.xtra  <= wdata;
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < RX_MAX; g++) begin : g_rx
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          rx_q[g] <= '0;
        else if (rx_we && (rx_idx == 2'(g)))
          rx_q[g] <= rx_byte;
      end
    end
  endgenerate

  always_comb begin
    case (addr)
      OFS_CTRL:  rdata = {busy, ctrl_q};
      OFS_CMD:   rdata = txb_q.cmd;
      OFS_ADR_L: rdata = txb_q.adr_l;
      OFS_ADR_M: rdata = txb_q.adr_m;
      OFS_ADR_H: rdata = txb_q.adr_h;
      OFS_RX0:   rdata = rx_q[0];
      OFS_RX1:   rdata = rx_q[1];
      default:   rdata = rx_q[2];
    endcase
  end

  AST_TX_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(txb_q)) else $error("tx bytes moved while busy"); // R9
  AST_RX_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> busy) else $error("receive write outside transfer"); // R5

endmodule

// File: rtl/spi_sx_div.sv
module spi_sx_div #(
  parameter int HALF_FAST = 1,
  parameter int HALF_SLOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);

  localparam int HMAX = (HALF_FAST > HALF_SLOW) ? HALF_FAST : HALF_SLOW;
  localparam int CW   = (HMAX > 1) ? $clog2(HMAX) : 1;
  localparam logic [CW-1:0] LIM_FAST = CW'(HALF_FAST - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(HALF_SLOW - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim  = fast ? LIM_FAST : LIM_SLOW;
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run) else $error("divider tick while stopped"); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim)) else $error("divider count past limit"); // R7

endmodule

// File: rtl/spi_sx_seq.sv
module spi_sx_seq
  import spi_sx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        start_code,
  input  logic [1:0]        start_rcnt,
  input  logic              start_fast,
  input  tx_bytes_t         txb,
  input  logic              tick,
  input  logic              miso,
  output logic              run,
  output logic              fast,
  output logic              busy,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic              rx_we,
  output logic [1:0]        rx_idx,
  output logic [BYTE_W-1:0] rx_byte
);

  sq_state_t              st_q;
  logic [TX_VEC_W-1:0]    tx_sh_q;
  logic [BIT_CNT_W-1:0]   bit_q, txn_q, tot_q, rx_pos, bit_nx;
  logic [BYTE_W-2:0]      rx_sh_q;
  logic                   sclk_q, cs_n_q, mosi_q, fast_q;
  logic                   rise_ev, fall_ev, last_fall, rx_phase;

  assign run       = (st_q == SQ_SHIFT) || (st_q == SQ_TAIL);
  assign fast      = fast_q;
  assign busy      = (st_q != SQ_IDLE);
  assign sclk      = sclk_q;
  assign cs_n      = cs_n_q;
  assign mosi      = mosi_q;

  // Named events for the assertions and the receive path.
  assign rise_ev   = (st_q == SQ_SHIFT) && tick && !sclk_q;
  assign fall_ev   = (st_q == SQ_SHIFT) && tick && sclk_q;
  assign last_fall = fall_ev && (bit_q == tot_q - 1'b1);
  assign rx_phase  = (bit_q >= txn_q);
  assign rx_pos    = bit_q - txn_q;
  assign bit_nx    = bit_q + 1'b1;

  assign rx_we     = rise_ev && rx_phase && (rx_pos[2:0] == 3'd7);
  assign rx_idx    = rx_pos[4:3];
  assign rx_byte   = {rx_sh_q, miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      tx_sh_q <= '0;
      bit_q   <= '0;
      txn_q   <= '0;
      tot_q   <= '0;
      rx_sh_q <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      mosi_q  <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start) begin
          tx_sh_q <= pack_tx(start_code, txb);
          mosi_q  <= pack_tx(start_code, txb)[TX_VEC_W-1];
          txn_q   <= tx_bits(start_code);
          tot_q   <= all_bits(start_code, start_rcnt);
          bit_q   <= '0;
          fast_q  <= start_fast;
          cs_n_q  <= 1'b0;
          sclk_q  <= 1'b0;
          st_q    <= SQ_SHIFT;
        end
        SQ_SHIFT: begin
          if (rise_ev) begin
            sclk_q <= 1'b1;
            if (rx_phase) rx_sh_q <= {rx_sh_q[BYTE_W-3:0], miso};
          end else if (fall_ev) begin
            sclk_q <= 1'b0;
            if (last_fall) begin
              mosi_q <= 1'b0;
              st_q   <= SQ_TAIL;
            end else begin
              bit_q   <= bit_nx;
              tx_sh_q <= tx_sh_q << 1;
              mosi_q  <= (bit_nx < txn_q) ? tx_sh_q[TX_VEC_W-2] : 1'b0;
            end
          end
        end
        SQ_TAIL: if (tick) begin
          cs_n_q <= 1'b1;
          st_q   <= SQ_DONE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk) else $error("sclk high while deselected"); // R6
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk) |-> $stable(mosi)) else $error("mosi moved while sclk high"); // R6
  AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy) else $error("selected while not busy"); // R8
  AST_BUSY_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy) else $error("busy gone at deselect"); // R8
  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !busy) else $error("busy late after deselect"); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !cs_n)) else $error("start not taken"); // R2
  AST_START_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy) else $error("start while busy"); // R9
  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_SHIFT) |-> (bit_q < tot_q)) else $error("bit index past end"); // R3

endmodule

// File: rtl/spi_short_xfer.sv
module spi_short_xfer
  import spi_sx_pkg::*;
#(
  parameter int HALF_FAST = 1,
  parameter int HALF_SLOW = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);

  logic              busy, start, start_fast, run, fast, tick, rx_we;
  logic [1:0]        start_code, start_rcnt, rx_idx;
  logic [BYTE_W-1:0] rx_byte;
  tx_bytes_t         txb;

  spi_sx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .busy(busy), .rx_we(rx_we), .rx_idx(rx_idx),
    .rx_byte(rx_byte), .start(start), .start_code(start_code),
    .start_rcnt(start_rcnt), .start_fast(start_fast), .txb(txb)
  );

  spi_sx_div #(.HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .fast(fast), .tick(tick)
  );

  spi_sx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_code(start_code),
    .start_rcnt(start_rcnt), .start_fast(start_fast), .txb(txb), .tick(tick),
    .miso(miso), .run(run), .fast(fast), .busy(busy), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
  );

endmodule

// File: tb/test_spi_short_xfer.sv
`timescale 1ns/1ps
module test_spi_short_xfer;

  localparam int HF = 2;
  localparam int HS = 5;
  localparam int NV = 7;

  logic       clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       sclk, cs_n, mosi, miso;

  int nchk = 0, nbad = 0;
  int rise_count = 0, cap_n = 0, cs_falls = 0, cur_txbits = 0;
  logic [63:0] cap = '0;
  logic [23:0] cur_resp = '0;
  time t_rise = 0;
  int  per_ns = 0;

  always #10 clk = ~clk;

  spi_short_xfer #(.HALF_FAST(HF), .HALF_SLOW(HS)) i_spi_short_xfer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  // Device model: response bits follow the outgoing bytes, MSB first.
  assign miso = (rise_count >= cur_txbits && rise_count < cur_txbits + 24) ?
                cur_resp[23 - (rise_count - cur_txbits)] : 1'b0;

  always @(negedge cs_n) begin
    rise_count = 0; cap = '0; cap_n = 0; per_ns = 0;
    cs_falls = cs_falls + 1;
  end

  always @(posedge sclk) begin
    if (rise_count == 1) per_ns = int'($time - t_rise);
    t_rise = $time;
    cap = {cap[62:0], mosi};
    cap_n = cap_n + 1;
    rise_count = rise_count + 1;
  end

  // Vector: ctrl, cmd, off2, off3, off4, off7, 24-bit response.
  localparam logic [71:0] VEC [NV] = '{
    {8'h50, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 24'hA1B2C3},
    {8'h4D, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h3C, 24'h1F2E3D},
    {8'h56, 8'h03, 8'h11, 8'h22, 8'h33, 8'h00, 24'h5A0000},
    {8'h5B, 8'h02, 8'h44, 8'h55, 8'h66, 8'hC7, 24'h81FF00},
    {8'h4C, 8'hAB, 8'h00, 8'h00, 8'h00, 8'h00, 24'hEF4017},
    {8'h47, 8'h0B, 8'h9A, 8'h8B, 8'h7C, 8'hE1, 24'h960000},
    {8'h59, 8'h05, 8'h00, 8'h00, 8'h00, 8'h77, 24'h3355AA}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic int nbytes_out(input logic [1:0] code);
    int t [4] = '{1, 2, 4, 5};
    return t[code];
  endfunction

  // Expected outgoing stream, right aligned, in wire order.
  function automatic logic [39:0] wire_tx(input logic [1:0] code,
      input logic [7:0] c, a2, a3, a4, x);
    logic [39:0] r = '0;
    if (code == 2'd0) r = {32'h0, c};
    if (code == 2'd1) r = {24'h0, c, x};
    if (code == 2'd2) r = {8'h0, c, a4, a3, a2};
    if (code == 2'd3) r = {c, a4, a3, a2, x};
    return r;
  endfunction

  task automatic wait_idle();
    logic [7:0] d;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); rd(3'd0, d);
      if (!d[7]) return;
    end
  endtask

  task automatic run_vec(input logic [71:0] v, input int idx);
    logic [7:0] ctrl, d;
    logic [1:0] code, rc;
    int nt, expbits;
    logic [63:0] txpart;
    ctrl = v[71:64]; code = ctrl[1:0]; rc = ctrl[3:2];
    wr(3'd1, v[63:56]); wr(3'd2, v[55:48]); wr(3'd3, v[47:40]);
    wr(3'd4, v[39:32]); wr(3'd7, v[31:24]);
    nt = nbytes_out(code);
    cur_txbits = 8 * nt; cur_resp = v[23:0];
    expbits = 8 * (nt + int'(rc));
    wr(3'd0, ctrl);
    rd(3'd0, d);
    chk(d[7] == 1'b1, $sformatf("R2 busy after start v%0d", idx), 64'(d[7]), 1);
    chk(cs_n == 1'b0, $sformatf("R8 cs low after start v%0d", idx), 64'(cs_n), 0);
    @(posedge cs_n);
    @(negedge clk); rd(3'd0, d);
    chk(d[7] == 1'b1, $sformatf("R8 busy at deselect v%0d", idx), 64'(d[7]), 1);
    @(negedge clk); rd(3'd0, d);
    chk(d[7] == 1'b0, $sformatf("R8 busy cleared v%0d", idx), 64'(d[7]), 0);
    chk(cap_n == expbits, $sformatf("R3 bit count v%0d", idx), 64'(cap_n), 64'(expbits));
    txpart = cap >> (8 * int'(rc));
    chk(txpart == 64'(wire_tx(code, v[63:56], v[55:48], v[47:40], v[39:32], v[31:24])),
        $sformatf("R4 wire order v%0d", idx), txpart,
        64'(wire_tx(code, v[63:56], v[55:48], v[47:40], v[39:32], v[31:24])));
    if (rc != 0)
      chk((cap & ((64'd1 << (8 * int'(rc))) - 1)) == 0, $sformatf("R6 mosi low rx v%0d", idx),
          cap & ((64'd1 << (8 * int'(rc))) - 1), 0);
    chk(per_ns == (ctrl[4] ? 2 * HF * 20 : 2 * HS * 20), $sformatf("R7 period v%0d", idx),
        64'(per_ns), 64'(ctrl[4] ? 2 * HF * 20 : 2 * HS * 20));
    for (int k = 0; k < 3; k++) begin
      if (k < int'(rc)) begin
        rd(3'(5 + k), d);
        chk(d == cur_resp[23 - 8 * k -: 8], $sformatf("R5 rx byte %0d v%0d", k, idx),
            64'(d), 64'(cur_resp[23 - 8 * k -: 8]));
      end
    end
    rd(3'd0, d);
    chk(d[6:0] == ctrl[6:0], $sformatf("R2 ctrl readback v%0d", idx), 64'(d), 64'(ctrl[6:0]));
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", nchk + 1, nbad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    int f0;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R1 pins in reset",
        64'({cs_n, sclk, mosi}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk(d == 8'h00, $sformatf("R1 offset %0d after reset", a), 64'(d), 0);
    end

    for (int v = 0; v < NV; v++) run_vec(VEC[v], v);

    // R5: offset 7 read returns third rx byte even after writing it.
    run_vec({8'h5C, 8'h9F, 8'h0, 8'h0, 8'h0, 8'h0, 24'h123456}, 100);
    wr(3'd7, 8'hD4);
    rd(3'd7, d);
    chk(d == 8'h56, "R5 offset 7 reads rx", 64'(d), 64'h56);
    // R10: offsets 5 and 6 are not writable.
    wr(3'd5, 8'hAA); wr(3'd6, 8'hBB);
    rd(3'd5, d); chk(d == 8'h12, "R10 offset 5 write ignored", 64'(d), 64'h12);
    rd(3'd6, d); chk(d == 8'h34, "R10 offset 6 write ignored", 64'(d), 64'h34);
    // R5: one-byte read keeps offsets 6 and 7.
    run_vec({8'h54, 8'h05, 8'h0, 8'h0, 8'h0, 8'h0, 24'hC90000}, 101);
    rd(3'd6, d); chk(d == 8'h34, "R5 offset 6 retained", 64'(d), 64'h34);
    rd(3'd7, d); chk(d == 8'h56, "R5 offset 7 retained", 64'(d), 64'h56);

    // R2: invalid start field starts nothing.
    f0 = cs_falls;
    wr(3'd0, 8'h35);
    repeat (30) @(negedge clk);
    rd(3'd0, d);
    chk(d == 8'h35, "R2 invalid field no busy, stored", 64'(d), 64'h35);
    chk(cs_falls == f0 && cs_n == 1'b1, "R2 invalid field no select", 64'(cs_falls - f0), 0);

    // R9: writes during a transfer are ignored.
    wr(3'd1, 8'h11); wr(3'd2, 8'h21); wr(3'd3, 8'h31); wr(3'd4, 8'h41); wr(3'd7, 8'h71);
    cur_txbits = 40; cur_resp = 24'h0F0E0D;
    f0 = cs_falls;
    wr(3'd0, 8'h5F);
    repeat (10) @(negedge clk);
    wr(3'd0, 8'h40);
    wr(3'd1, 8'hEE);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(cap_n == 64, "R9 second ctrl write ignored (bits)", 64'(cap_n), 64);
    chk(cs_falls == f0 + 1, "R9 no second transfer", 64'(cs_falls - f0), 1);
    chk(cap[63:24] == 40'h1141312171, "R9 wire bytes unchanged", 64'(cap[63:24]), 64'h1141312171);
    rd(3'd1, d); chk(d == 8'h11, "R9 cmd write ignored", 64'(d), 64'h11);
    rd(3'd0, d); chk(d == 8'h5F, "R9 ctrl readback kept", 64'(d), 64'h5F);
    rd(3'd7, d); chk(d == 8'h0D, "R5 third rx byte", 64'(d), 64'h0D);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule